// File: doc/BRIEF.md
# (7,4) Cyclic Code Encoder and Single-Error Corrector

This block contains two independent datapaths for a systematic (7,4) cyclic block code with the fixed generator g(x) = x^3 + x + 1. The encoder takes a 4-bit message and produces a 7-bit codeword. The message sits in the top four bits and the three check bits sit below it. The check bits are the modulo-2 remainder of x^3·m(x) divided by g(x).

The decoder takes a 7-bit received word and divides it by g(x). The remainder is the syndrome. A nonzero syndrome is matched against the syndrome that each single-bit error position would produce, and the matching bit is inverted. The decoder returns the syndrome, an error flag, the corrected word and the recovered message.

Each direction has its own valid/ready output register, so a result appears one clock after its input is accepted. A stalled consumer holds the result in place and stops further input.

Bit i of every 7-bit bus is the coefficient of x^i, so bit 6 is the leftmost bit of the written codeword. The widths and the generator are parameters. The defaults give the (7,4) code.

Top module: `cyc74_codec`

## Requirements
- R1: `enc_code[6:3]` equals the accepted message and `enc_code[2:0]` is the remainder of x^3·m(x) mod x^3+x+1 (generator bits 4'b1011). For example, message 4'b0111 (1+x+x^2) encodes to 7'b0111010.
- R2: For any of the 16 valid codewords, the decoder outputs syndrome 3'b000, `dec_err` = 0, `dec_fixed` equal to the input word, and `dec_msg` equal to the word's bits 6:3.
- R3: `dec_syndrome` is the received word mod g(x). For a single error at bit i (i = 0 to 6), the syndrome is 001, 010, 100, 011, 110, 111 and 101 respectively. For example, 7'b1111010 gives 3'b101.
- R4: A word with exactly one flipped bit is restored: `dec_err` = 1, `dec_fixed` is the original codeword and `dec_msg` is its message. For example, 7'b0111011 becomes 7'b0111010.
- R5: The decoder inverts at most one bit. For a nonzero syndrome it inverts exactly the bit i whose x^i mod g(x) equals the syndrome, even when more than one bit was in error.
- R6: A transfer accepted on a rising edge (in_valid and in_ready both high) raises out_valid and presents its result right after that edge. Out_valid is low before that edge.
- R7: While out_valid is high and out_ready is low, the output data and out_valid hold and in_ready is low. A new input is taken on the edge where out_ready returns high.
- R8: After reset both out_valid outputs are low and both in_ready outputs are high.
- R9: The encoder and decoder paths do not interact. A stall on one path does not stop the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_in_valid | input | 1 | Message present |
| enc_in_ready | output | 1 | Encoder can accept |
| enc_msg | input | 4 | Message, bit i = coefficient of x^i |
| enc_out_valid | output | 1 | Codeword present |
| enc_out_ready | input | 1 | Consumer takes codeword |
| enc_code | output | 7 | Systematic codeword |
| dec_in_valid | input | 1 | Received word present |
| dec_in_ready | output | 1 | Decoder can accept |
| dec_word | input | 7 | Received word |
| dec_out_valid | output | 1 | Decoder result present |
| dec_out_ready | input | 1 | Consumer takes result |
| dec_syndrome | output | 3 | Remainder of received word by g(x) |
| dec_err | output | 1 | Nonzero syndrome |
| dec_fixed | output | 7 | Corrected word |
| dec_msg | output | 4 | Bits 6:3 of the corrected word |

## Verification
All 16 messages are encoded and compared with a codeword table derived by hand from the generator. This confirms both the remainder and the systematic placement. Each codeword is then decoded unaltered and with each of its seven single-bit flips, which is 112 error cases. This separates a wrong syndrome mapping, a wrong flip position and a wrong message slice. A double error shows that only one bit is ever flipped. Stall and idle-cycle tests check the register latency, the holding of a stalled result and the independence of the two paths.

// File: rtl/cyc74_pkg.sv
package cyc74_pkg;

    // Modulo-2 remainder of val by generator g of degree r.
    function automatic logic [31:0] gf2_mod(input logic [31:0] val,
                                            input logic [31:0] g,
                                            input int          r);
        logic [31:0] v;
        v = val;
        for (int i = 31; i >= 0; i--) begin
            if (i >= r && v[i]) begin
                v = v ^ (g << (i - r));
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/cyc74_enc_core.sv
module cyc74_enc_core #(
    parameter int          N     = 7,
    parameter int          K     = 4,
    parameter logic [31:0] GPOLY = 32'hB
) (
    input  logic [K-1:0] msg,
    output logic [N-1:0] code
);
    import cyc74_pkg::*;
    localparam int R = N - K;

    logic [R-1:0] rem;

    always_comb begin
        rem  = R'(gf2_mod(32'(msg) << R, GPOLY, R));
        code = {msg, rem};
    end
endmodule

// File: rtl/cyc74_dec_core.sv
module cyc74_dec_core #(
    parameter int          N     = 7,
    parameter int          K     = 4,
    parameter logic [31:0] GPOLY = 32'hB
) (
    input  logic [N-1:0]   word,
    output logic [N-K-1:0] syn,
    output logic           err,
    output logic [N-1:0]   fixed,
    output logic [K-1:0]   msg
);
    import cyc74_pkg::*;
    localparam int R = N - K;

    logic [N-1:0] hit;

    always_comb begin
        syn = R'(gf2_mod(32'(word), GPOLY, R));
    end

    // One comparator per bit position against x^i mod g(x).
    for (genvar i = 0; i < N; i++) begin : g_pos
        localparam logic [R-1:0] SIG = R'(gf2_mod(32'(1) << i, GPOLY, R));
        assign hit[i] = (syn == SIG);
    end

    always_comb begin
        err   = |syn;
        fixed = word ^ (err ? hit : '0);
        msg   = fixed[N-1:R];
    end
endmodule

// File: rtl/cyc74_stage.sv
module cyc74_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        in_ready = !st_q.vld || out_ready;
        if (in_ready) begin
            st_d.vld = in_valid;
            if (in_valid) begin
                st_d.dat = in_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;
endmodule

// File: rtl/cyc74_codec.sv
module cyc74_codec #(
    parameter int          N     = 7,
    parameter int          K     = 4,
    parameter logic [31:0] GPOLY = 32'hB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enc_in_valid,
    output logic             enc_in_ready,
    input  logic [K-1:0]     enc_msg,
    output logic             enc_out_valid,
    input  logic             enc_out_ready,
    output logic [N-1:0]     enc_code,
    input  logic             dec_in_valid,
    output logic             dec_in_ready,
    input  logic [N-1:0]     dec_word,
    output logic             dec_out_valid,
    input  logic             dec_out_ready,
    output logic [N-K-1:0]   dec_syndrome,
    output logic             dec_err,
    output logic [N-1:0]     dec_fixed,
    output logic [K-1:0]     dec_msg
);
    localparam int R  = N - K;
    localparam int DW = R + 1 + N + K;

    logic [N-1:0]  enc_code_c;
    logic [R-1:0]  syn_c;
    logic          err_c;
    logic [N-1:0]  fixed_c;
    logic [K-1:0]  msg_c;
    logic [DW-1:0] dec_pack_q;

    cyc74_enc_core #(.N(N), .K(K), .GPOLY(GPOLY)) u_enc (
        .msg  (enc_msg),
        .code (enc_code_c)
    );

    cyc74_dec_core #(.N(N), .K(K), .GPOLY(GPOLY)) u_dec (
        .word  (dec_word),
        .syn   (syn_c),
        .err   (err_c),
        .fixed (fixed_c),
        .msg   (msg_c)
    );

    cyc74_stage #(.W(N)) u_enc_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (enc_in_valid),
        .in_ready  (enc_in_ready),
        .in_data   (enc_code_c),
        .out_valid (enc_out_valid),
        .out_ready (enc_out_ready),
        .out_data  (enc_code)
    );

    cyc74_stage #(.W(DW)) u_dec_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (dec_in_valid),
        .in_ready  (dec_in_ready),
        .in_data   ({syn_c, err_c, fixed_c, msg_c}),
        .out_valid (dec_out_valid),
        .out_ready (dec_out_ready),
        .out_data  (dec_pack_q)
    );

    assign {dec_syndrome, dec_err, dec_fixed, dec_msg} = dec_pack_q;
endmodule

// File: rtl/cyc74_codec_chk.sv
module cyc74_codec_chk #(
    parameter int N = 7,
    parameter int K = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           enc_in_valid,
    input logic           enc_in_ready,
    input logic [K-1:0]   enc_msg,
    input logic           enc_out_valid,
    input logic           enc_out_ready,
    input logic [N-1:0]   enc_code,
    input logic           dec_in_valid,
    input logic           dec_in_ready,
    input logic [N-1:0]   dec_word,
    input logic           dec_out_valid,
    input logic           dec_out_ready,
    input logic [N-K-1:0] dec_syndrome,
    input logic [N-1:0]   dec_fixed
);
    // R1
    enc_systematic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_in_valid && enc_in_ready |=> enc_code[N-1:N-K] == $past(enc_msg));

    // R6
    enc_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_in_valid && enc_in_ready |=> enc_out_valid);

    // R6
    dec_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_in_valid && dec_in_ready |=> dec_out_valid);

    // R7
    enc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        enc_out_valid && !enc_out_ready |=> enc_out_valid && $stable(enc_code));

    // R7
    dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_out_valid && !dec_out_ready |=>
            dec_out_valid && $stable(dec_fixed) && $stable(dec_syndrome));

    // R5
    dec_one_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_in_valid && dec_in_ready |=> $countones(dec_fixed ^ $past(dec_word)) <= 1);

    // R8
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !enc_out_valid && !dec_out_valid);
endmodule

bind cyc74_codec cyc74_codec_chk #(.N(N), .K(K)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enc_in_valid  (enc_in_valid),
    .enc_in_ready  (enc_in_ready),
    .enc_msg       (enc_msg),
    .enc_out_valid (enc_out_valid),
    .enc_out_ready (enc_out_ready),
    .enc_code      (enc_code),
    .dec_in_valid  (dec_in_valid),
    .dec_in_ready  (dec_in_ready),
    .dec_word      (dec_word),
    .dec_out_valid (dec_out_valid),
    .dec_out_ready (dec_out_ready),
    .dec_syndrome  (dec_syndrome),
    .dec_fixed     (dec_fixed)
);

// File: tb/cyc74_codec_tb.sv
module cyc74_codec_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enc_in_valid = 1'b0, enc_out_ready = 1'b1;
    logic [3:0] enc_msg = '0;
    logic       dec_in_valid = 1'b0, dec_out_ready = 1'b1;
    logic [6:0] dec_word = '0;
    logic       enc_in_ready, enc_out_valid, dec_in_ready, dec_out_valid, dec_err;
    logic [6:0] enc_code, dec_fixed;
    logic [2:0] dec_syndrome;
    logic [3:0] dec_msg;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Expected codewords for messages 0..15 (R1).
    localparam logic [6:0] CW [16] = '{
        7'h00, 7'h0B, 7'h16, 7'h1D, 7'h27, 7'h2C, 7'h31, 7'h3A,
        7'h45, 7'h4E, 7'h53, 7'h58, 7'h62, 7'h69, 7'h74, 7'h7F};
    // Syndrome of a single error at bit i (R3).
    localparam logic [2:0] SYN [7] = '{3'b001, 3'b010, 3'b100, 3'b011,
                                       3'b110, 3'b111, 3'b101};

    always #4 clk = ~clk;

    cyc74_codec u_dut (
        .clk(clk), .rst_n(rst_n),
        .enc_in_valid(enc_in_valid), .enc_in_ready(enc_in_ready), .enc_msg(enc_msg),
        .enc_out_valid(enc_out_valid), .enc_out_ready(enc_out_ready), .enc_code(enc_code),
        .dec_in_valid(dec_in_valid), .dec_in_ready(dec_in_ready), .dec_word(dec_word),
        .dec_out_valid(dec_out_valid), .dec_out_ready(dec_out_ready),
        .dec_syndrome(dec_syndrome), .dec_err(dec_err), .dec_fixed(dec_fixed),
        .dec_msg(dec_msg)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic enc_one(input logic [3:0] m, input string req);
        enc_in_valid = 1'b1;
        enc_msg      = m;
        @(negedge clk);
        check(enc_out_valid && enc_code == CW[m], req, {enc_out_valid, enc_code}, {1'b1, CW[m]});
        enc_in_valid = 1'b0;
    endtask

    task automatic dec_one(input logic [6:0] w, input logic [2:0] s, input logic [6:0] fx,
                           input string req);
        logic ok;
        dec_in_valid = 1'b1;
        dec_word     = w;
        @(negedge clk);
        ok = dec_out_valid && dec_syndrome == s && dec_err == (s != 0) &&
             dec_fixed == fx && dec_msg == fx[6:3];
        check(ok, req, {dec_out_valid, dec_syndrome, dec_err, dec_fixed, dec_msg},
              {1'b1, s, s != 3'b0, fx, fx[6:3]});
        dec_in_valid = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(!enc_out_valid && !dec_out_valid && enc_in_ready && dec_in_ready, "R8",
              {enc_out_valid, dec_out_valid, enc_in_ready, dec_in_ready}, 4'b0011);

        // Table walk: R1 encode, R2 clean decode, R3/R4 every single flip.
        for (int m = 0; m < 16; m++) begin
            enc_one(4'(m), "R1");
            dec_one(CW[m], 3'b000, CW[m], "R2");
            for (int i = 0; i < 7; i++) begin
                dec_one(CW[m] ^ (7'd1 << i), SYN[i], CW[m], "R3_R4");
            end
        end

        // Directed corner cases.
        dec_one(7'b1111010, 3'b101, 7'b0111010, "R3");
        dec_one(7'b0111011, 3'b001, 7'b0111010, "R4");
        // R5 double error: bits 0,1 wrong gives syndrome 011, flips bit 3.
        dec_one(7'b0111010 ^ 7'b0000011, 3'b011, 7'b0110001, "R5");

        // R6 latency: idle, then valid only after the accepting edge.
        @(negedge clk);
        check(!dec_out_valid, "R6", {31'b0, dec_out_valid}, 0);
        dec_in_valid = 1'b1;
        dec_word     = CW[3];
        @(posedge clk);
        #1;
        check(dec_out_valid && dec_fixed == CW[3], "R6", {dec_out_valid, dec_fixed}, {1'b1, CW[3]});
        @(negedge clk);
        dec_in_valid = 1'b0;

        // R7 back-pressure on encoder, R9 decoder keeps flowing meanwhile.
        enc_out_ready = 1'b0;
        enc_in_valid  = 1'b1;
        enc_msg       = 4'd5;
        @(negedge clk);
        check(enc_out_valid && enc_code == CW[5] && !enc_in_ready, "R7",
              {enc_out_valid, enc_in_ready, enc_code}, {2'b10, CW[5]});
        enc_msg = 4'd9;
        dec_one(CW[12] ^ 7'h10, SYN[4], CW[12], "R9");
        check(enc_out_valid && enc_code == CW[5], "R7", {enc_out_valid, enc_code}, {1'b1, CW[5]});
        enc_out_ready = 1'b1;
        @(negedge clk);
        check(enc_out_valid && enc_code == CW[9], "R7", {enc_out_valid, enc_code}, {1'b1, CW[9]});
        enc_in_valid = 1'b0;

        // R9 decoder stalled, encoder still accepts.
        dec_out_ready = 1'b0;
        dec_in_valid  = 1'b1;
        dec_word      = CW[6];
        @(negedge clk);
        dec_in_valid = 1'b0;
        enc_one(4'd14, "R9");
        check(dec_out_valid && dec_fixed == CW[6] && !dec_in_ready, "R9",
              {dec_out_valid, dec_in_ready, dec_fixed}, {2'b10, CW[6]});
        dec_out_ready = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(!enc_out_valid && !dec_out_valid, "R6",
              {enc_out_valid, dec_out_valid}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule